// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Timing Mode

This block buffers data words between two unrelated clock domains. Words enter on the write clock under a write enable. They leave on the read clock. The write and read pointers cross between the domains in Gray code through a chain of synchronising flops. Each side works out its own status from its own pointer and the synchronised copy of the other side's pointer. Neither clock has to be faster than the other.

A mode input is captured while master reset is held, and it sets how the block behaves:

- **Standard mode.** Every word needs an explicit read request. The two status outputs mean "empty" and "full".
- **Fall-through mode.** The oldest word is placed on the output without any request. A read request only consumes it. The same two status outputs then mean "word presented" and "space available".

The block also has the following controls:

- **Partial reset.** Empties the buffer but keeps the captured mode.
- **Retransmit.** Rewinds reading to the first word written since the last reset, with a fixed latency.
- **Half-full flag.** Reported in the write domain.
- **Output enable.** Zeroes the data output and drops its valid qualifier.

Top module: `xclk_fifo`

## Requirements
- R1: `mode_sel` is captured on each clock while `mrst_n` is low. 0 selects standard mode and 1 selects fall-through mode. A partial reset leaves the captured mode unchanged, whatever `mode_sel` shows.
- R2: In standard mode, `rd_stat` is 1 exactly when no unread word is visible to the read side. `wr_stat` is 1 exactly when DEPTH words are stored.
- R3: In fall-through mode, `rd_stat` is 1 exactly when a valid word is presented on `rd_data`. `wr_stat` is 1 while storage can accept a write. Without reads, DEPTH+1 words fit, counting the presented word.
- R4: In fall-through mode, a word written into an empty buffer appears on `rd_data` with `rd_stat`=1 on the third rising `rd_clk` edge after the write edge, with `rd_en` held low.
- R5: Words come out in the order they were accepted, with no loss and no duplication, under any mix of write and read gaps on independent clocks.
- R6: A write attempted while the buffer is full is dropped. No word is stored on a `wr_clk` edge where `wr_en` is 0.
- R7: In standard mode, `rd_en` while empty has no effect. A read of a non-empty buffer puts the word on `rd_data` after that `rd_clk` edge.
- R8: In fall-through mode, a presented word stays on `rd_data` until a `rd_en` edge consumes it.
- R9: `half_full` is 1 when the write side sees more than DEPTH/2 words stored.
- R10: After master or partial reset the buffer is empty. In standard mode `rd_stat`=1 and `wr_stat`=0; in fall-through mode `rd_stat`=0 and `wr_stat`=1. `half_full`=0.
- R11: A one-cycle `retx` pulse rewinds reading to the first word written since reset. In standard mode the next read returns that word. In fall-through mode `rd_stat` is 0 after the `retx` edge, and that word is presented after the next `rd_clk` edge.
- R12: While `oe` is 0, `rd_data` is all zeros and `rd_data_en` is 0. Raising `oe` again shows the unchanged held word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| rd_clk | input | 1 | Read-domain clock |
| mrst_n | input | 1 | Master reset, active low, asynchronous assert |
| prst_n | input | 1 | Partial reset, active low, keeps mode |
| mode_sel | input | 1 | Timing mode captured during master reset (1 = fall-through) |
| wr_en | input | 1 | Write request, sampled on `wr_clk` |
| wr_data | input | DATA_W | Word to store |
| wr_stat | output | 1 | Full (standard) or space available (fall-through) |
| half_full | output | 1 | More than DEPTH/2 words stored |
| rd_en | input | 1 | Read request, sampled on `rd_clk` |
| retx | input | 1 | Retransmit request, sampled on `rd_clk` |
| oe | input | 1 | Output enable |
| rd_data | output | DATA_W | Output word, zero when `oe` is low |
| rd_data_en | output | 1 | Qualifier for `rd_data` |
| rd_stat | output | 1 | Empty (standard) or word presented (fall-through) |

## Verification
The hardest state to reach is a fall-through retransmit while a later word is already sitting in the output register. The stimulus writes a short burst and lets the first word fall through. The scoreboard then consumes exactly two words and halts, so that the third word is held when `retx` is pulsed. The bench then samples `rd_stat` and `rd_data` on the two read edges that follow, to confirm the fixed rewind latency. The write-full boundary is reached the same way: the reader is stalled, and the bench counts the accepted writes against `wr_stat` until the flag turns.

// File: rtl/xfifo_pkg.sv
`timescale 1ns/1ps
package xfifo_pkg;
   typedef enum logic {
      MODE_STD  = 1'b0,
      MODE_FALL = 1'b1
   } xfifo_mode_e;

   function automatic logic [31:0] to_gray(input logic [31:0] b);
      return b ^ (b >> 1);
   endfunction

   function automatic logic [31:0] from_gray(input logic [31:0] g);
      logic [31:0] b;
      b = g;
      for (int s = 1; s < 32; s = s * 2) begin
         b = b ^ (b >> s);
      end
      return b;
   endfunction
endpackage

// File: rtl/xfifo_sync.sv
`timescale 1ns/1ps
module xfifo_sync #(
   parameter int WIDTH  = 5,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= '0;
            else        chain[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/xfifo_mem.sv
`timescale 1ns/1ps
module xfifo_mem #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16,
   parameter int AW     = $clog2(DEPTH)
) (
   input  logic              wclk,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [AW-1:0]     raddr,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] store [DEPTH];

   always_ff @(posedge wclk) begin
      if (we) store[waddr] <= wdata;
   end

   assign rdata = store[raddr];
endmodule

// File: rtl/xfifo_wr_ctl.sv
`timescale 1ns/1ps
module xfifo_wr_ctl
   import xfifo_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int AW    = $clog2(DEPTH),
   parameter int PW    = AW + 1
) (
   input  logic          wclk,
   input  logic          clr_n,
   input  logic          mrst_n,
   input  logic          mode_sel,
   input  logic          wr_en,
   input  logic [PW-1:0] rgray_s,
   output logic          we,
   output logic [AW-1:0] waddr,
   output logic [PW-1:0] wgray,
   output logic          wr_stat,
   output logic          half_full
);
   localparam logic [PW-1:0] FULL_CNT = PW'(DEPTH);
   localparam logic [PW-1:0] HALF_CNT = PW'(DEPTH / 2);

   xfifo_mode_e   mode_q;
   logic [PW-1:0] wbin;
   logic [PW-1:0] wbin_nxt;
   logic [PW-1:0] rbin_s;
   logic [PW-1:0] occ;
   logic          full;

   always_ff @(posedge wclk) begin
      if (!mrst_n) mode_q <= xfifo_mode_e'(mode_sel);
   end

   assign rbin_s   = PW'(from_gray(32'(rgray_s)));
   assign occ      = wbin - rbin_s;
   assign full     = (occ == FULL_CNT);
   assign we       = wr_en && !full;
   assign wbin_nxt = wbin + PW'(we);
   assign waddr    = wbin[AW-1:0];

   always_ff @(posedge wclk or negedge clr_n) begin
      if (!clr_n) begin
         wbin  <= '0;
         wgray <= '0;
      end else begin
         wbin  <= wbin_nxt;
         wgray <= PW'(to_gray(32'(wbin_nxt)));
      end
   end

   assign wr_stat   = (mode_q == MODE_FALL) ? !full : full;
   assign half_full = (occ > HALF_CNT);

   // R6
   full_drop_chk: assert property (@(posedge wclk) disable iff (!clr_n)
      (full && wr_en) |=> $stable(wbin));

   // R6
   idle_hold_chk: assert property (@(posedge wclk) disable iff (!clr_n)
      !wr_en |=> $stable(wbin));

   // R2
   occ_bound_chk: assert property (@(posedge wclk) disable iff (!clr_n)
      occ <= FULL_CNT);
endmodule

// File: rtl/xfifo_rd_ctl.sv
`timescale 1ns/1ps
module xfifo_rd_ctl
   import xfifo_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16,
   parameter int AW     = $clog2(DEPTH),
   parameter int PW     = AW + 1
) (
   input  logic              rclk,
   input  logic              clr_n,
   input  logic              mrst_n,
   input  logic              mode_sel,
   input  logic              rd_en,
   input  logic              retx,
   input  logic [PW-1:0]     wgray_s,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [AW-1:0]     raddr,
   output logic [PW-1:0]     rgray,
   output logic [DATA_W-1:0] dout_q,
   output logic              rd_stat
);
   xfifo_mode_e   mode_q;
   logic [PW-1:0] rbin;
   logic [PW-1:0] rbin_nxt;
   logic [PW-1:0] wbin_s;
   logic          empty;
   logic          ovalid;
   logic          pop;

   always_ff @(posedge rclk) begin
      if (!mrst_n) mode_q <= xfifo_mode_e'(mode_sel);
   end

   assign wbin_s = PW'(from_gray(32'(wgray_s)));
   assign empty  = (rbin == wbin_s);
   assign raddr  = rbin[AW-1:0];

   always_comb begin
      if (mode_q == MODE_FALL) pop = !empty && (!ovalid || rd_en) && !retx;
      else                     pop = !empty && rd_en && !retx;
   end

   always_comb begin
      if (retx) rbin_nxt = '0;
      else      rbin_nxt = rbin + PW'(pop);
   end

   always_ff @(posedge rclk or negedge clr_n) begin
      if (!clr_n) begin
         rbin   <= '0;
         rgray  <= '0;
         dout_q <= '0;
         ovalid <= 1'b0;
      end else begin
         rbin  <= rbin_nxt;
         rgray <= PW'(to_gray(32'(rbin_nxt)));
         if (pop) dout_q <= mem_rdata;
         if (retx || mode_q != MODE_FALL) ovalid <= 1'b0;
         else if (pop)                    ovalid <= 1'b1;
         else if (rd_en)                  ovalid <= 1'b0;
      end
   end

   assign rd_stat = (mode_q == MODE_FALL) ? ovalid : empty;

   // R7
   empty_read_chk: assert property (@(posedge rclk) disable iff (!clr_n)
      (mode_q == MODE_STD && empty && rd_en && !retx) |=> $stable(rbin));

   // R11
   rewind_chk: assert property (@(posedge rclk) disable iff (!clr_n)
      retx |=> (rbin == '0) && !ovalid);

   // R8
   hold_word_chk: assert property (@(posedge rclk) disable iff (!clr_n)
      (mode_q == MODE_FALL && ovalid && !rd_en && !retx) |=> (ovalid && $stable(dout_q)));
endmodule

// File: rtl/xclk_fifo.sv
`timescale 1ns/1ps
module xclk_fifo #(
   parameter int DATA_W      = 8,
   parameter int DEPTH       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              wr_clk,
   input  logic              rd_clk,
   input  logic              mrst_n,
   input  logic              prst_n,
   input  logic              mode_sel,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic              wr_stat,
   output logic              half_full,
   input  logic              rd_en,
   input  logic              retx,
   input  logic              oe,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_data_en,
   output logic              rd_stat
);
   localparam int AW = $clog2(DEPTH);
   localparam int PW = AW + 1;

   if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("xclk_fifo: DEPTH must be a power of two of at least 4");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("xclk_fifo: SYNC_STAGES must be at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("xclk_fifo: DATA_W must be positive");
   end

   logic              clr_n;
   logic              we;
   logic [AW-1:0]     waddr;
   logic [AW-1:0]     raddr;
   logic [PW-1:0]     wgray;
   logic [PW-1:0]     rgray;
   logic [PW-1:0]     wgray_s;
   logic [PW-1:0]     rgray_s;
   logic [DATA_W-1:0] mem_rdata;
   logic [DATA_W-1:0] dout_q;

   assign clr_n = mrst_n & prst_n;

   xfifo_wr_ctl #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_wr (
      .wclk(wr_clk), .clr_n(clr_n), .mrst_n(mrst_n), .mode_sel(mode_sel),
      .wr_en(wr_en), .rgray_s(rgray_s), .we(we), .waddr(waddr),
      .wgray(wgray), .wr_stat(wr_stat), .half_full(half_full)
   );

   xfifo_sync #(.WIDTH(PW), .STAGES(SYNC_STAGES)) u_w2r (
      .clk(rd_clk), .rst_n(clr_n), .d(wgray), .q(wgray_s)
   );

   xfifo_sync #(.WIDTH(PW), .STAGES(SYNC_STAGES)) u_r2w (
      .clk(wr_clk), .rst_n(clr_n), .d(rgray), .q(rgray_s)
   );

   xfifo_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_mem (
      .wclk(wr_clk), .we(we), .waddr(waddr), .wdata(wr_data),
      .raddr(raddr), .rdata(mem_rdata)
   );

   xfifo_rd_ctl #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW), .PW(PW)) u_rd (
      .rclk(rd_clk), .clr_n(clr_n), .mrst_n(mrst_n), .mode_sel(mode_sel),
      .rd_en(rd_en), .retx(retx), .wgray_s(wgray_s), .mem_rdata(mem_rdata),
      .raddr(raddr), .rgray(rgray), .dout_q(dout_q), .rd_stat(rd_stat)
   );

   assign rd_data    = oe ? dout_q : '0;
   assign rd_data_en = oe;

   // R12
   oe_quiet_chk: assert property (@(posedge rd_clk) disable iff (!clr_n)
      !oe |-> (rd_data == '0) && !rd_data_en);
endmodule

// File: tb/xclk_fifo_test.sv
`timescale 1ns/1ps
module xclk_fifo_test;
   localparam int W = 8;
   localparam int DEPTH = 16;

   logic wr_clk = 1'b0, rd_clk = 1'b0;
   logic mrst_n = 1'b0, prst_n = 1'b1, mode_sel = 1'b0;
   logic wr_en = 1'b0, rd_en = 1'b0, retx = 1'b0, oe = 1'b1;
   logic [W-1:0] wr_data = '0;
   logic [W-1:0] rd_data;
   logic wr_stat, half_full, rd_data_en, rd_stat;

   always #2   wr_clk = ~wr_clk;
   always #3.5 rd_clk = ~rd_clk;

   xclk_fifo #(.DATA_W(W), .DEPTH(DEPTH), .SYNC_STAGES(2)) uut (
      .wr_clk(wr_clk), .rd_clk(rd_clk), .mrst_n(mrst_n), .prst_n(prst_n),
      .mode_sel(mode_sel), .wr_en(wr_en), .wr_data(wr_data), .wr_stat(wr_stat),
      .half_full(half_full), .rd_en(rd_en), .retx(retx), .oe(oe),
      .rd_data(rd_data), .rd_data_en(rd_data_en), .rd_stat(rd_stat)
   );

   int checks = 0, errors = 0;
   bit done = 1'b0;
   bit fwft = 1'b0, rd_go = 1'b0, force_rd = 1'b0, rnd_rd = 1'b0, pend = 1'b0;
   logic [W-1:0] sb_q[$];
   logic [W-1:0] hist[$];

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare(input logic [W-1:0] got);
      logic [W-1:0] exp;
      if (sb_q.size() == 0) begin
         chk(1'b0, "R5 unexpected word", int'(got), -1);
      end else begin
         exp = sb_q.pop_front();
         chk(got == exp, "R5 data order", int'(got), int'(exp));
      end
   endtask

   // monitor: consumes and compares output words
   initial begin
      forever begin
         @(negedge rd_clk);
         if (!fwft) begin
            if (pend) compare(rd_data);
            rd_en = force_rd | (rd_go & !rd_stat & (!rnd_rd || $urandom_range(0, 3) != 0));
            pend  = rd_en & !rd_stat;
         end else begin
            pend = 1'b0;
            if (rd_go && rd_stat && (!rnd_rd || $urandom_range(0, 3) != 0)) begin
               compare(rd_data);
               rd_en = 1'b1;
            end else begin
               rd_en = 1'b0;
            end
         end
      end
   end

   // driver: one write attempt; pushes to scoreboard only if the flag allows it
   task automatic wr_word(input logic [W-1:0] d, output bit acc);
      @(negedge wr_clk);
      wr_en = 1'b1;
      wr_data = d;
      acc = fwft ? wr_stat : !wr_stat;
      if (acc) begin
         sb_q.push_back(d);
         hist.push_back(d);
      end
      @(posedge wr_clk);
      #0.5 wr_en = 1'b0;
   endtask

   task automatic do_mrst(input bit m);
      rd_go = 1'b0;
      repeat (4) @(negedge rd_clk);
      mode_sel = m;
      fwft = m;
      mrst_n = 1'b0;
      #80 mrst_n = 1'b1;
      sb_q.delete();
      hist.delete();
      repeat (3) @(negedge rd_clk);
   endtask

   task automatic do_prst(input bit pin);
      rd_go = 1'b0;
      repeat (4) @(negedge rd_clk);
      mode_sel = pin;
      prst_n = 1'b0;
      #40 prst_n = 1'b1;
      sb_q.delete();
      hist.delete();
      repeat (3) @(negedge rd_clk);
   endtask

   task automatic drain(input string tag);
      rd_go = 1'b1;
      for (int i = 0; i < 3000; i++) begin
         @(negedge rd_clk);
         if (sb_q.size() == 0) break;
      end
      repeat (10) @(negedge rd_clk);
      rd_go = 1'b0;
      repeat (3) @(negedge rd_clk);
      chk(sb_q.size() == 0, {tag, " R5 all words delivered"}, sb_q.size(), 0);
      if (fwft) chk(rd_stat == 1'b0, {tag, " R3 no word left"}, rd_stat, 0);
      else      chk(rd_stat == 1'b1, {tag, " R2 empty after drain"}, rd_stat, 1);
   endtask

   task automatic stream(input int n, input logic [W-1:0] base);
      bit acc;
      rnd_rd = 1'b1;
      rd_go = 1'b1;
      for (int i = 0; i < n; i++) begin
         repeat ($urandom_range(0, 2)) @(negedge wr_clk);
         do begin
            wr_word(base + W'(i), acc);
         end while (!acc);
      end
      drain("stream");
      rnd_rd = 1'b0;
   endtask

   initial begin
      bit acc;
      int cnt;
      logic [W-1:0] dummy;

      // ---------------- standard mode ----------------
      do_mrst(1'b0);
      // R10
      chk(rd_stat == 1'b1, "R10 std reset empty", rd_stat, 1);
      chk(wr_stat == 1'b0, "R10 std reset not full", wr_stat, 0);
      chk(half_full == 1'b0, "R10 reset half_full", half_full, 0);

      // fill without reads: R9 and R2 boundaries
      for (int i = 0; i < DEPTH; i++) begin
         wr_word(W'(8'h10 + i), acc);
         if (i == DEPTH/2 - 1) chk(half_full == 1'b0, "R9 half_full at DEPTH/2", half_full, 0);
         if (i == DEPTH/2)     chk(half_full == 1'b1, "R9 half_full at DEPTH/2+1", half_full, 1);
         if (i == DEPTH - 2)   chk(wr_stat == 1'b0, "R2 not full at DEPTH-1", wr_stat, 0);
         if (i == DEPTH - 1)   chk(wr_stat == 1'b1, "R2 full at DEPTH", wr_stat, 1);
      end
      // R6: write while full is dropped (not pushed; monitor flags any extra word)
      wr_word(8'hEE, acc);
      chk(acc == 1'b0, "R6 full write refused", acc, 0);
      drain("R6 fill");

      // R7: reads while empty are ignored
      force_rd = 1'b1;
      repeat (5) @(negedge rd_clk);
      force_rd = 1'b0;
      wr_word(8'h5A, acc);
      drain("R7 empty read");

      // R5 streaming in standard mode
      stream(40, 8'h40);

      // R11 retransmit in standard mode
      do_prst(1'b0);
      for (int i = 0; i < 5; i++) wr_word(W'(8'hA0 + i), acc);
      repeat (6) @(negedge rd_clk);
      rd_go = 1'b1;
      while (sb_q.size() > 2) @(negedge rd_clk);
      rd_go = 1'b0;
      repeat (3) @(negedge rd_clk);
      @(negedge rd_clk) retx = 1'b1;
      @(negedge rd_clk) retx = 1'b0;
      sb_q = hist;
      drain("R11 std retransmit");

      // R1: partial reset keeps standard mode even with mode_sel at 1
      do_prst(1'b1);
      wr_word(8'h66, acc);
      repeat (6) @(negedge rd_clk);
      chk(rd_stat == 1'b0, "R1 mode kept after partial reset", rd_stat, 0);
      drain("R1");

      // ---------------- fall-through mode ----------------
      do_mrst(1'b1);
      // R10 / R3
      chk(rd_stat == 1'b0, "R10 fall reset no word", rd_stat, 0);
      chk(wr_stat == 1'b1, "R10 fall reset space", wr_stat, 1);

      // R4: latency of three read edges
      @(negedge wr_clk);
      wr_en = 1'b1;
      wr_data = 8'h3C;
      sb_q.push_back(8'h3C);
      hist.push_back(8'h3C);
      @(posedge wr_clk);
      fork
         begin #0.5 wr_en = 1'b0; end
      join_none
      @(posedge rd_clk);
      @(posedge rd_clk);
      #1 chk(rd_stat == 1'b0, "R4 no word after two edges", rd_stat, 0);
      @(posedge rd_clk);
      #1 chk(rd_stat == 1'b1 && rd_data == 8'h3C, "R4 word after third edge", int'(rd_data), 8'h3C);

      // R8: word held while not consumed
      repeat (10) @(negedge rd_clk);
      chk(rd_stat == 1'b1 && rd_data == 8'h3C, "R8 word held", int'(rd_data), 8'h3C);

      // R3: capacity DEPTH+1 counting the presented word
      repeat (6) @(negedge wr_clk);
      cnt = 0;
      for (int i = 0; i < DEPTH + 4; i++) begin
         wr_word(W'(8'h80 + i), acc);
         if (!acc) break;
         cnt++;
      end
      chk(cnt == DEPTH, "R3 accepted beyond presented word", cnt, DEPTH);
      chk(wr_stat == 1'b0, "R3 no space when full", wr_stat, 0);
      drain("R3 capacity");

      // R5 streaming in fall-through mode
      stream(40, 8'hC0);

      // R10: partial reset empties a loaded buffer
      for (int i = 0; i < 3; i++) wr_word(W'(8'h20 + i), acc);
      repeat (6) @(negedge rd_clk);
      do_prst(1'b0);
      chk(rd_stat == 1'b0, "R10 partial reset clears word", rd_stat, 0);
      chk(wr_stat == 1'b1, "R10 partial reset space", wr_stat, 1);

      // R11 retransmit in fall-through mode
      for (int i = 0; i < 4; i++) wr_word(W'(8'hB0 + i), acc);
      repeat (8) @(negedge rd_clk);
      rd_go = 1'b1;
      while (sb_q.size() > 2) @(negedge rd_clk);
      rd_go = 1'b0;
      repeat (3) @(negedge rd_clk);
      @(negedge rd_clk) retx = 1'b1;
      @(posedge rd_clk);
      #1 chk(rd_stat == 1'b0, "R11 fall word dropped on rewind", rd_stat, 0);
      @(negedge rd_clk) retx = 1'b0;
      @(posedge rd_clk);
      #1 chk(rd_stat == 1'b1 && rd_data == 8'hB0, "R11 first word presented", int'(rd_data), 8'hB0);
      sb_q = hist;
      drain("R11 fall retransmit");

      // R12 output enable
      wr_word(8'h77, acc);
      repeat (6) @(negedge rd_clk);
      oe = 1'b0;
      #1 chk(rd_data == '0 && rd_data_en == 1'b0, "R12 oe low quiet", int'(rd_data), 0);
      oe = 1'b1;
      #1 chk(rd_data == 8'h77 && rd_data_en == 1'b1, "R12 oe high word", int'(rd_data), 8'h77);
      drain("R12");

      dummy = '0;
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #400us;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule